// File: doc/BRIEF.md
# Bus and CPU clock phase generator

This block turns one master clock into the full set of timing levels for a system whose processor runs fast and whose shared bus runs slow. The processor clock runs at half the master rate. The bus clock runs eight processor cycles per period. A companion bus clock at twice the bus rate feeds DRAM control. Two slot strobes mark the processor cycles in which a slow bus access starts and ends. Two enable strobes, each one master cycle wide, tell downstream logic clocked by the master clock when the processor clock is about to rise or fall.

Every output is a register bit or a decode of register bits, all updated on the master clock. A synchronous down-counter produces the clock levels. A shift register, loaded with the bus clock once per processor cycle, places the slot strobes. The bus clock and its double-rate companion change level only on master edges where the processor clock falls, so any logic that samples them on the processor clock sees a stable value.

Master cycle numbering used below: after reset is released, the first master cycle is m = 0. A slot is one processor cycle that starts at a processor falling edge; slot s spans master cycles 2s and 2s+1 counted from the last rise of `bus_clk`.

Top module: `busclk_phase_gen`

## Requirements
- R1: `cpu_clk` toggles on every master edge. It is low in master cycle m = 0 after reset release and high in every odd m.
- R2: `bus_clk` has a period of 16 master cycles (8 processor cycles). It is high for master cycles m mod 16 in 0..7 and low for 8..15.
- R3: `bus_clk` and `bus_clk_x2` change level only on a master edge where `cpu_clk` goes from high to low.
- R4: `bus_clk_x2` has a period of 8 master cycles. It is high for m mod 8 in 0..3, so it rises together with `bus_clk`.
- R5: `access_start` is high exactly in slot 1 (master cycles m mod 16 in 2..3) of each bus period and low elsewhere.
- R6: `access_end` is high exactly in slot 3 (master cycles m mod 16 in 6..7), the last slot of the `bus_clk` high phase, and low elsewhere.
- R7: `cpu_rise` is high exactly in the master cycles where `cpu_clk` is low and will be high next. `cpu_fall` is high exactly in the master cycles where `cpu_clk` is high and will be low next.
- R8: While `rst_n` is sampled low, the block holds `cpu_clk` = 1, `bus_clk` = 0, `bus_clk_x2` = 0, `access_start` = 0, `access_end` = 0, `cpu_rise` = 0 and `cpu_fall` = 1. A reset applied mid-run restarts the sequence from m = 0.
- R9: `access_start` and `access_end` are never high together, and neither is high before the first `bus_clk` rise after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_clk | output | 1 | Processor clock, half the master rate |
| cpu_rise | output | 1 | High in the master cycle before a `cpu_clk` rise |
| cpu_fall | output | 1 | High in the master cycle before a `cpu_clk` fall |
| bus_clk | output | 1 | Bus clock, one period per eight processor cycles |
| bus_clk_x2 | output | 1 | Bus clock at twice the bus rate, for DRAM timing |
| access_start | output | 1 | Slot strobe where a slow access begins |
| access_end | output | 1 | Slot strobe where a slow access ends |

## Verification
The bench walks through several whole bus periods after reset and compares every output in every master cycle against a phase computed from the cycle count. It also applies reset in the middle of a period to show that the sequence restarts cleanly. The corner cases are these. The bus clock could move on a processor rising edge: a counter that counts the wrong way or uses the wrong reset value does this. The slot strobes could land one processor cycle early or late: a shift register loaded with the present bus clock level instead of the coming one does this. A strobe could also fire in the first period after reset because the shift register still holds stale bits. Finally, reset could leave the processor clock low, so the first processor edge after reset would be a rise and not a fall.

// File: rtl/bpg_pkg.sv
// Package: bpg_pkg
// Shared constants and helpers for the bus/processor clock phase generator.
// Assumes a processor clock at exactly half the master clock rate.
package bpg_pkg;

    // Master cycles per processor cycle; fixed by the counter structure.
    localparam int unsigned MASTER_PER_CPU = 2;

    // Default number of processor cycles per bus clock period.
    localparam int unsigned DEF_CPU_PER_BUS = 8;

    // Counter width needed for a given bus ratio.
    function automatic int unsigned phase_cnt_width(input int unsigned cpu_per_bus);
        return $clog2(MASTER_PER_CPU * cpu_per_bus);
    endfunction

endpackage

// File: rtl/bpg_down_counter.sv
// Module: bpg_down_counter
// Free-running synchronous down-counter that sets every clock phase.
// It also gives the value it will hold after the next edge, so that a
// downstream register can load a coming level. Reset value is zero. The
// first edge after reset wraps it to all ones.
module bpg_down_counter #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt
);

    // Next value: one less than the present value, wrapping at zero.
    always_comb begin
        cnt_nxt = cnt_q - CNT_W'(1);
    end

    // Count register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end

endmodule

// File: rtl/bpg_slot_marker.sv
// Module: bpg_slot_marker
// Shift register that samples the bus clock once per processor slot. Taps of
// the register are combined to decode which slot follows the last bus clock
// rise. Assumes that adv is high in the master cycle before each slot
// boundary, and that level_nxt is the bus clock level after that boundary.
module bpg_slot_marker #(
    parameter int unsigned CPU_PER_BUS = 8,
    parameter int unsigned START_SLOT  = 1,
    parameter int unsigned END_SLOT    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic level_nxt,
    output logic start_o,
    output logic end_o
);

    localparam int unsigned SR_W = CPU_PER_BUS + 1;

    logic [SR_W-1:0]        hist_q;
    logic [CPU_PER_BUS-1:0] slot_hit;

    // History register: bit 0 holds the bus level of the present slot.
    always_ff @(posedge clk) begin
        if (!rst_n)   hist_q <= '0;
        else if (adv) hist_q <= {hist_q[SR_W-2:0], level_nxt};
    end

    // One decode per slot: the bus clock rose exactly s slots ago.
    for (genvar s = 0; s < CPU_PER_BUS; s++) begin : g_slot
        assign slot_hit[s] = hist_q[s] & ~hist_q[s+1];
    end

    // Select the two configured slots.
    assign start_o = slot_hit[START_SLOT];
    assign end_o   = slot_hit[END_SLOT];

endmodule

// File: rtl/busclk_phase_gen.sv
// Module: busclk_phase_gen
// Top of the phase generator. A down-counter drives the processor clock, the
// bus clock and the double-rate bus clock from its bits. A slot marker
// places the access start and end strobes. Assumes CPU_PER_BUS is a power
// of two, at least 4, and that both slot indices are below it.
module busclk_phase_gen #(
    parameter int unsigned CPU_PER_BUS = bpg_pkg::DEF_CPU_PER_BUS,
    parameter int unsigned START_SLOT  = 1,
    parameter int unsigned END_SLOT    = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic cpu_clk,
    output logic cpu_rise,
    output logic cpu_fall,
    output logic bus_clk,
    output logic bus_clk_x2,
    output logic access_start,
    output logic access_end
);

    localparam int unsigned CNT_W = bpg_pkg::phase_cnt_width(CPU_PER_BUS);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;

    // Phase counter.
    bpg_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    // Clock levels taken from counter bits; the low bit is inverted.
    always_comb begin
        cpu_clk    = ~cnt_q[0];
        bus_clk    = cnt_q[CNT_W-1];
        bus_clk_x2 = cnt_q[CNT_W-2];
        cpu_rise   = ~cpu_clk;
        cpu_fall   = cpu_clk;
    end

    // Slot strobes, advanced once per processor cycle at its falling edge.
    bpg_slot_marker #(
        .CPU_PER_BUS (CPU_PER_BUS),
        .START_SLOT  (START_SLOT),
        .END_SLOT    (END_SLOT)
    ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (cpu_fall),
        .level_nxt (cnt_nxt[CNT_W-1]),
        .start_o   (access_start),
        .end_o     (access_end)
    );

endmodule

// File: rtl/bpg_checker.sv
// Module: bpg_checker
// Assertions on the phase generator outputs, bound to the top module.
module bpg_checker (
    input logic clk,
    input logic rst_n,
    input logic cpu_clk,
    input logic cpu_rise,
    input logic cpu_fall,
    input logic bus_clk,
    input logic bus_clk_x2,
    input logic access_start,
    input logic access_end
);

    logic armed;

    // Arm the history checks one cycle after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R1
    cpu_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        cpu_clk != $past(cpu_clk));

    // R3
    bus_edge_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (bus_clk != $past(bus_clk)) |-> ($past(cpu_clk) && !cpu_clk));

    // R3
    bus_x2_edge_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (bus_clk_x2 != $past(bus_clk_x2)) |-> ($past(cpu_clk) && !cpu_clk));

    // R4
    bus_x2_rise_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $rose(bus_clk) |-> bus_clk_x2);

    // R5
    start_slot_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $rose(access_start) |-> (bus_clk && !cpu_clk));

    // R6
    end_slot_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $fell(access_end) |-> $fell(bus_clk));

    // R7
    rise_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rise |=> cpu_clk);

    // R7
    fall_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_fall |=> !cpu_clk);

    // R8
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (cpu_clk && !bus_clk && !bus_clk_x2 && !access_start && !access_end));

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({access_start, access_end}));

endmodule

bind busclk_phase_gen bpg_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_clk      (cpu_clk),
    .cpu_rise     (cpu_rise),
    .cpu_fall     (cpu_fall),
    .bus_clk      (bus_clk),
    .bus_clk_x2   (bus_clk_x2),
    .access_start (access_start),
    .access_end   (access_end)
);

// File: tb/busclk_phase_gen_tb.sv
// Bench: walks several bus periods and compares each output per master cycle.
module busclk_phase_gen_tb;

    localparam int PERIOD_M = 16;   // master cycles per bus period
    localparam int START_S  = 1;
    localparam int END_S    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_clk, cpu_rise, cpu_fall, bus_clk, bus_clk_x2, access_start, access_end;

    int checks = 0;
    int failures = 0;
    logic prev_cpu, prev_bus, prev_x2;
    bit have_prev = 1'b0;

    always #2 clk = ~clk;

    busclk_phase_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_clk(cpu_clk), .cpu_rise(cpu_rise),
        .cpu_fall(cpu_fall), .bus_clk(bus_clk), .bus_clk_x2(bus_clk_x2),
        .access_start(access_start), .access_end(access_end)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // R8: reset values.
    task automatic check_reset_state();
        chk("R8", "cpu_clk", cpu_clk, 1'b1);
        chk("R8", "bus_clk", bus_clk, 1'b0);
        chk("R8", "bus_clk_x2", bus_clk_x2, 1'b0);
        chk("R8", "access_start", access_start, 1'b0);
        chk("R8", "access_end", access_end, 1'b0);
        chk("R8", "cpu_rise", cpu_rise, 1'b0);
        chk("R8", "cpu_fall", cpu_fall, 1'b1);
        prev_cpu = cpu_clk; prev_bus = bus_clk; prev_x2 = bus_clk_x2; have_prev = 1'b1;
    endtask

    // Expected outputs in master cycle m after reset release.
    task automatic check_cycle(input int m);
        int u;
        int slot;
        u = m % PERIOD_M;
        slot = u / 2;
        chk("R1", "cpu_clk", cpu_clk, logic'(u % 2 == 1));
        chk("R2", "bus_clk", bus_clk, logic'(u < PERIOD_M / 2));
        chk("R4", "bus_clk_x2", bus_clk_x2, logic'((u % 8) < 4));
        chk("R5", "access_start", access_start, logic'(slot == START_S));
        chk("R6", "access_end", access_end, logic'(slot == END_S));
        chk("R7", "cpu_rise", cpu_rise, logic'(u % 2 == 0));
        chk("R7", "cpu_fall", cpu_fall, logic'(u % 2 == 1));
        chk("R9", "strobes_exclusive", access_start & access_end, 1'b0);
        if (have_prev && (bus_clk !== prev_bus || bus_clk_x2 !== prev_x2))
            chk("R3", "bus_change_on_cpu_fall", prev_cpu & ~cpu_clk, 1'b1);
        prev_cpu = cpu_clk; prev_bus = bus_clk; prev_x2 = bus_clk_x2; have_prev = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        for (int m = 0; m < 3 * PERIOD_M + 5; m++) begin
            @(negedge clk);
            check_cycle(m);
        end
        // R8: reset in the middle of a bus period restarts the sequence.
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state();
        @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        for (int m = 0; m < 2 * PERIOD_M; m++) begin
            @(negedge clk);
            check_cycle(m);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #20000;
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule